// File: doc/BRIEF.md
# CD Sector Descrambler and EDC Checker

This block takes the raw byte stream of a CD-ROM sector, one byte per strobe. It finds the start-of-sector marker and undoes the scrambling. It picks out the address header and the sub-header and checks the error detection code on the sector kinds that carry one. Each incoming byte has its bit order flipped and is then XORed with a keystream from a 15-bit shift register. The shift register is reseeded at the first byte after every sync marker.

The four header bytes land in registers that downstream firmware can read. A ready flag and an error flag qualify them. User bytes appear on a strobed output with their position in the sector, and only while collection is enabled. Header capture, format decoding and the error code check run whether or not collection is on. One cycle after the last byte of a sector, a single-cycle status strobe carries a summary byte. The summary reports the check result, the header validity, the sync timing and the decoded sector format.

Top module: `cd_sector_checker`

## Requirements
- R1: Each accepted byte is bit-reversed and, from sector position 12 onward, XORed with a keystream from a 15-bit shift register with feedback polynomial x^15+x+1. The register is seeded with 0x0001 at the byte after sync. Keystream bit i of a byte is the register's bit 0 before its i-th shift. Each shift moves the register right and feeds bit0 XOR bit1 into bit 14. The plain byte appears on `out_byte` with its position on `out_pos`, one cycle after the byte is accepted.
- R2: A sector starts only on the exact sequence 0x00, ten 0xFF, 0x00, seen while no sector is open. A run of fewer or more than ten 0xFF does not start a sector. Bytes outside a sector produce no output strobe.
- R3: Positions 12, 13, 14 and 15 are loaded into `hdr_min`, `hdr_sec`, `hdr_frm` and `hdr_mode`. `hdr_rdy` rises one cycle after position 15 is accepted and falls one cycle after the next sync completes. The header registers keep their values until they are overwritten.
- R4: `collect_en` low suppresses `out_vld`, and has no effect on the header registers, the flags or the status strobe.
- R5: A header is in error if any of positions 12 to 14 is not valid BCD, or if the mode byte is above 2. `hdr_err` then rises together with `hdr_rdy`. The status byte reports bit 1 set, a format code of 00 and no check failure.
- R6: For mode 1, the check residue over positions 0 to 2067 must be zero, or status bit 0 is set. The residue uses the reflected polynomial x^32+x^31+x^16+x^15+x^4+x^3+x+1 with an initial value of 0, taking each byte least significant bit first. The code occupies positions 2064 to 2067, least significant byte first.
- R7: For mode 2, bit 5 of position 18 selects form 2 when set. For form 1, the same residue over positions 16 to 2075 must be zero, or status bit 0 is set. Form 2 never sets bit 0.
- R8: One cycle after position 2351 is accepted, `stat_wr` pulses for one cycle. `stat_byte` then holds: bits 7:5 zero; bits 4:3 the format code (00 no checked format, 01 mode 1, 10 mode 2 form 1, 11 mode 2 form 2); bit 2 sync late; bit 1 header error; bit 0 check failure.
- R9: Status bit 2 is set when a sector has already ended since reset and the next sync does not complete on exactly the 12th accepted byte after that end. The first sector after reset reports 0.
- R10: For a sector collected with `collect_en` high, the last user byte and the status strobe appear in the same cycle.
- R11: While in reset and after it, `out_vld`, `stat_wr`, `hdr_rdy` and `hdr_err` are low and the header registers are zero.
- R12: A cycle with `in_vld` low changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte strobe |
| in_byte | input | 8 | Raw (scrambled, bit-reversed) sector byte |
| collect_en | input | 1 | Enables output of user bytes |
| out_vld | output | 1 | User byte strobe |
| out_byte | output | 8 | Descrambled byte |
| out_pos | output | 12 | Position of `out_byte` within the sector |
| hdr_rdy | output | 1 | Header registers hold the current sector header |
| hdr_err | output | 1 | Captured header is malformed |
| hdr_min | output | 8 | Header minute byte |
| hdr_sec | output | 8 | Header second byte |
| hdr_frm | output | 8 | Header frame byte |
| hdr_mode | output | 8 | Header mode byte |
| stat_wr | output | 1 | Sector status strobe |
| stat_byte | output | 8 | Sector status byte |

## Verification
The final byte of a sector has two effects on the same clock edge: the data path emits the last user byte, and the sequencer emits the status strobe. The bench streams collected sectors back to back with idle cycles spread among the bytes. Its reference model expects both strobes in that one cycle and compares both values there. It also counts the cycles in which the two strobes coincide, and that count must match the number of collected sectors. A second overlap is a sector ending and the next sync starting on the following byte: the late flag must stay clear for that sector and rise only when extra bytes come between them.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;

    localparam logic [14:0] LFSR_SEED     = 15'h0001;
    localparam logic [31:0] EDC_POLY_REFL = 32'hD801_8001;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_M1   = 2'd1,
        FMT_M2F1 = 2'd2,
        FMT_M2F2 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [2:0] spare;
        fmt_e       fmt;
        logic       sync_late;
        logic       hdr_bad;
        logic       edc_bad;
    } status_t;

    typedef struct packed {
        logic [7:0] minute;
        logic [7:0] second;
        logic [7:0] frame;
        logic [7:0] mode;
    } hdr_t;

    function automatic logic [7:0] bitrev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] lfsr_key8(input logic [14:0] s);
        logic [14:0] r;
        logic [7:0]  k;
        r = s;
        for (int i = 0; i < 8; i++) begin
            k[i] = r[0];
            r    = {r[0] ^ r[1], r[14:1]};
        end
        return k;
    endfunction

    function automatic logic [14:0] lfsr_next8(input logic [14:0] s);
        logic [14:0] r;
        r = s;
        for (int i = 0; i < 8; i++) r = {r[0] ^ r[1], r[14:1]};
        return r;
    endfunction

    function automatic logic [31:0] edc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ EDC_POLY_REFL;
        end
        return r;
    endfunction

    function automatic logic [31:0] sync_edc(input int nbytes);
        logic [31:0] c;
        c = '0;
        for (int i = 0; i < nbytes; i++)
            c = edc_byte(c, (i == 0 || i == nbytes - 1) ? 8'h00 : 8'hFF);
        return c;
    endfunction

    function automatic logic is_bcd(input logic [7:0] b);
        return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
    endfunction

endpackage

// File: rtl/cdsec_descram.sv
module cdsec_descram
    import cdsec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reseed,
    input  logic       step,
    input  logic [7:0] din,
    output logic [7:0] rev_o,
    output logic [7:0] dout
);
    logic [14:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || reseed) lfsr_q <= LFSR_SEED;
        else if (step)     lfsr_q <= lfsr_next8(lfsr_q);
    end

    assign rev_o = bitrev8(din);
    assign dout  = rev_o ^ lfsr_key8(lfsr_q);

    // a maximal-length register seeded non-zero never collapses to zero
    assert_lfsr_live_R1: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/cdsec_syncdet.sv
module cdsec_syncdet #(
    parameter int SYNC_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       clr,
    input  logic [7:0] din,
    output logic       hit
);
    localparam int FF_RUN = SYNC_BYTES - 2;
    localparam int CW     = $clog2(FF_RUN + 1);

    logic          armed_q;
    logic [CW-1:0] run_q;

    assign hit = en && (din == 8'h00) && armed_q && (run_q == CW'(FF_RUN));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (en) begin
            if (din == 8'h00) begin
                armed_q <= !hit;
                run_q   <= '0;
            end else if (din == 8'hFF && armed_q) begin
                if (run_q == CW'(FF_RUN)) begin
                    armed_q <= 1'b0;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                armed_q <= 1'b0;
                run_q   <= '0;
            end
        end
    end

    assert_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_q <= CW'(FF_RUN));
endmodule

// File: rtl/cdsec_edc.sv
module cdsec_edc
    import cdsec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] seed,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_nxt
);
    logic [31:0] crc_q;

    assign crc_nxt = edc_byte(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= '0;
        else if (load) crc_q <= seed;
        else if (upd)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/cd_sector_checker.sv
module cd_sector_checker
    import cdsec_pkg::*;
#(
    parameter int SECTOR_BYTES = 2352,
    parameter int SYNC_BYTES   = 12,
    parameter int HDR_BYTES    = 4,
    parameter int SUBHDR_BYTES = 8,
    parameter int USER_BYTES   = 2048,
    parameter int EDC_BYTES    = 4,
    parameter int FORM_BIT     = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_vld,
    input  logic [7:0]                      in_byte,
    input  logic                            collect_en,
    output logic                            out_vld,
    output logic [7:0]                      out_byte,
    output logic [$clog2(SECTOR_BYTES)-1:0] out_pos,
    output logic                            hdr_rdy,
    output logic                            hdr_err,
    output logic [7:0]                      hdr_min,
    output logic [7:0]                      hdr_sec,
    output logic [7:0]                      hdr_frm,
    output logic [7:0]                      hdr_mode,
    output logic                            stat_wr,
    output logic [7:0]                      stat_byte
);
    localparam int POS_W      = $clog2(SECTOR_BYTES);
    localparam int GAP_W      = 8;
    localparam int P_HDR0     = SYNC_BYTES;
    localparam int P_MODE     = SYNC_BYTES + HDR_BYTES - 1;
    localparam int P_SUBMODE  = SYNC_BYTES + HDR_BYTES + 2;
    localparam int P_M1_END   = SYNC_BYTES + HDR_BYTES + USER_BYTES + EDC_BYTES - 1;
    localparam int P_M2_START = SYNC_BYTES + HDR_BYTES;
    localparam int P_M2_END   = SYNC_BYTES + HDR_BYTES + SUBHDR_BYTES + USER_BYTES + EDC_BYTES - 1;
    localparam int P_LAST     = SECTOR_BYTES - 1;
    localparam logic [31:0] SYNC_SEED = sync_edc(SYNC_BYTES);

    logic             in_sec_q, have_prev_q, late_q, form2_q, crc_bad_q;
    logic [POS_W-1:0] pos_q;
    logic [GAP_W-1:0] gap_q;
    hdr_t             hdr_q;
    logic             hdr_rdy_q, hdr_err_q;
    logic             out_vld_q, stat_wr_q;
    logic [7:0]       out_byte_q;
    logic [POS_W-1:0] out_pos_q;
    status_t          stat_q;

    logic [7:0]  rev_b, plain_b;
    logic        sync_hit, acc;
    logic [31:0] edc_a_nxt, edc_b_nxt;
    logic [2:0]  bcd_ok;
    logic        hdr_bad_c;
    fmt_e        fmt_c;

    assign acc = in_vld && in_sec_q;

    cdsec_descram u_descram (
        .clk(clk), .rst(rst), .reseed(in_vld && sync_hit), .step(acc),
        .din(in_byte), .rev_o(rev_b), .dout(plain_b)
    );

    cdsec_syncdet #(.SYNC_BYTES(SYNC_BYTES)) u_sync (
        .clk(clk), .rst(rst), .en(in_vld && !in_sec_q), .clr(in_sec_q),
        .din(rev_b), .hit(sync_hit)
    );

    // whole-sector residue (mode 1), seeded with the sync pattern's residue
    cdsec_edc u_edc_full (
        .clk(clk), .rst(rst), .load(in_vld && sync_hit), .seed(SYNC_SEED),
        .upd(acc), .din(plain_b), .crc_nxt(edc_a_nxt)
    );

    // residue from the sub-header on (mode 2 form 1)
    cdsec_edc u_edc_sub (
        .clk(clk), .rst(rst),
        .load(acc && pos_q == POS_W'(P_M2_START - 1)), .seed(32'h0),
        .upd(acc && pos_q >= POS_W'(P_M2_START)), .din(plain_b),
        .crc_nxt(edc_b_nxt)
    );

    // BCD test of minute/second/frame, which sit in hdr_q[23:0] before the mode byte shifts in
    for (genvar g = 0; g < 3; g++) begin : g_bcd
        assign bcd_ok[g] = is_bcd(hdr_q[8*g +: 8]);
    end
    assign hdr_bad_c = !(&bcd_ok) || (plain_b > 8'd2);

    always_comb begin
        if (hdr_err_q)                 fmt_c = FMT_NONE;
        else if (hdr_q.mode == 8'd1)   fmt_c = FMT_M1;
        else if (hdr_q.mode == 8'd2)   fmt_c = form2_q ? FMT_M2F2 : FMT_M2F1;
        else                           fmt_c = FMT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sec_q    <= 1'b0;
            have_prev_q <= 1'b0;
            late_q      <= 1'b0;
            form2_q     <= 1'b0;
            crc_bad_q   <= 1'b0;
            pos_q       <= '0;
            gap_q       <= '0;
            hdr_q       <= '0;
            hdr_rdy_q   <= 1'b0;
            hdr_err_q   <= 1'b0;
            out_vld_q   <= 1'b0;
            out_byte_q  <= '0;
            out_pos_q   <= '0;
            stat_wr_q   <= 1'b0;
            stat_q      <= '0;
        end else begin
            out_vld_q <= 1'b0;
            stat_wr_q <= 1'b0;
            if (in_vld && !in_sec_q) begin
                if (gap_q != '1) gap_q <= gap_q + 1'b1;
                if (sync_hit) begin
                    in_sec_q  <= 1'b1;
                    pos_q     <= POS_W'(SYNC_BYTES);
                    late_q    <= have_prev_q && (gap_q != GAP_W'(SYNC_BYTES - 1));
                    hdr_rdy_q <= 1'b0;
                    hdr_err_q <= 1'b0;
                    crc_bad_q <= 1'b0;
                    form2_q   <= 1'b0;
                end
            end else if (acc) begin
                pos_q      <= pos_q + 1'b1;
                out_vld_q  <= collect_en;
                out_byte_q <= plain_b;
                out_pos_q  <= pos_q;
                if (pos_q >= POS_W'(P_HDR0) && pos_q <= POS_W'(P_MODE))
                    hdr_q <= {hdr_q[23:0], plain_b};
                if (pos_q == POS_W'(P_MODE)) begin
                    hdr_rdy_q <= 1'b1;
                    hdr_err_q <= hdr_bad_c;
                end
                if (pos_q == POS_W'(P_SUBMODE))
                    form2_q <= plain_b[FORM_BIT];
                if (pos_q == POS_W'(P_M1_END) && fmt_c == FMT_M1)
                    crc_bad_q <= (edc_a_nxt != '0);
                if (pos_q == POS_W'(P_M2_END) && fmt_c == FMT_M2F1)
                    crc_bad_q <= (edc_b_nxt != '0);
                if (pos_q == POS_W'(P_LAST)) begin
                    in_sec_q    <= 1'b0;
                    pos_q       <= '0;
                    gap_q       <= '0;
                    have_prev_q <= 1'b1;
                    stat_wr_q   <= 1'b1;
                    stat_q      <= '{spare: 3'b000, fmt: fmt_c, sync_late: late_q,
                                     hdr_bad: hdr_err_q, edc_bad: crc_bad_q};
                end
            end
        end
    end

    assign out_vld   = out_vld_q;
    assign out_byte  = out_byte_q;
    assign out_pos   = out_pos_q;
    assign hdr_rdy   = hdr_rdy_q;
    assign hdr_err   = hdr_err_q;
    assign hdr_min   = hdr_q.minute;
    assign hdr_sec   = hdr_q.second;
    assign hdr_frm   = hdr_q.frame;
    assign hdr_mode  = hdr_q.mode;
    assign stat_wr   = stat_wr_q;
    assign stat_byte = stat_q;

    assert_collect_gate_R4: assert property (@(posedge clk) disable iff (rst)
        out_vld_q |-> $past(collect_en));
    assert_err_needs_rdy_R5: assert property (@(posedge clk) disable iff (rst)
        hdr_err_q |-> hdr_rdy_q);
    assert_bad_hdr_no_fmt_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_q && stat_q.hdr_bad) |-> (stat_q.fmt == FMT_NONE && !stat_q.edc_bad));
    assert_form2_unchecked_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_q && stat_q.fmt == FMT_M2F2) |-> !stat_q.edc_bad);
    assert_stat_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        stat_wr_q |=> !stat_wr_q);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(in_vld) |-> (!out_vld_q && !stat_wr_q));
endmodule

// File: tb/sim_cd_sector_checker.sv
module sim_cd_sector_checker;
    localparam int SEC = 2352;

    logic        clk = 1'b0;
    logic        rst, in_vld, collect_en;
    logic [7:0]  in_byte;
    logic        out_vld, hdr_rdy, hdr_err, stat_wr;
    logic [7:0]  out_byte, hdr_min, hdr_sec, hdr_frm, hdr_mode, stat_byte;
    logic [11:0] out_pos;

    always #5 clk = ~clk;

    cd_sector_checker u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
        .collect_en(collect_en), .out_vld(out_vld), .out_byte(out_byte),
        .out_pos(out_pos), .hdr_rdy(hdr_rdy), .hdr_err(hdr_err),
        .hdr_min(hdr_min), .hdr_sec(hdr_sec), .hdr_frm(hdr_frm),
        .hdr_mode(hdr_mode), .stat_wr(stat_wr), .stat_byte(stat_byte)
    );

    int checks = 0, failures = 0, n_stat = 0, n_both = 0, slot_cnt = 0;

    bit          q_v[$], q_col[$], q_eov[$], q_esw[$], q_erdy[$], q_eerr[$];
    logic [7:0]  q_in[$], q_eob[$], q_esb[$];
    logic [11:0] q_eop[$];
    logic [31:0] q_ehdr[$];
    string       q_tag[$];

    logic [31:0] e_hdr = '0;
    bit          e_rdy = 0, e_err = 0;
    logic [14:0] g_lfsr = 15'h1;
    logic [7:0]  sec_buf [0:SEC-1];

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] edc_upd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 32'hD8018001;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic push_slot(input bit v, input logic [7:0] b, input bit col, input bit eov,
                             input logic [7:0] eob, input logic [11:0] eop, input bit esw,
                             input logic [7:0] esb, input string tag);
        q_v.push_back(v); q_in.push_back(b); q_col.push_back(col);
        q_eov.push_back(eov); q_eob.push_back(eob); q_eop.push_back(eop);
        q_esw.push_back(esw); q_esb.push_back(esb); q_tag.push_back(tag);
        q_ehdr.push_back(e_hdr); q_erdy.push_back(e_rdy); q_eerr.push_back(e_err);
    endtask

    // one byte, then every ninth slot an idle cycle (R12)
    task automatic feed(input logic [7:0] b, input bit col, input bit eov, input logic [7:0] eob,
                        input logic [11:0] eop, input bit esw, input logic [7:0] esb, input string tag);
        push_slot(1'b1, b, col, eov, eob, eop, esw, esb, tag);
        slot_cnt++;
        if (slot_cnt % 9 == 8) push_slot(1'b0, 8'hA5, col, 0, 0, 0, 0, 0, "R12");
    endtask

    task automatic noise(input logic [7:0] b);
        feed(b, 1'b1, 0, 0, 0, 0, 0, "R2");
    endtask

    task automatic build_sector(input int mode, input bit form2, input bit bad_edc,
                                input bit bad_hdr, input int seed);
        logic [31:0] c;
        for (int i = 0; i < SEC; i++) sec_buf[i] = 8'((i * 7 + seed * 13 + (i >> 3)) & 255);
        for (int i = 0; i < 12; i++) sec_buf[i] = (i == 0 || i == 11) ? 8'h00 : 8'hFF;
        sec_buf[12] = bad_hdr ? 8'h1A : 8'h12;
        sec_buf[13] = 8'h34;
        sec_buf[14] = 8'((seed % 7) * 16 + 3);
        sec_buf[15] = bad_hdr ? 8'd3 : 8'(mode);
        if (mode == 2) begin
            for (int k = 0; k < 2; k++) begin
                sec_buf[16 + 4*k] = 8'h01;
                sec_buf[17 + 4*k] = 8'h02;
                sec_buf[18 + 4*k] = form2 ? 8'h20 : 8'h00;
                sec_buf[19 + 4*k] = 8'h00;
            end
            c = '0;
            for (int i = 16; i <= 2071; i++) c = edc_upd(c, sec_buf[i]);
            for (int k = 0; k < 4; k++) sec_buf[2072 + k] = c[8*k +: 8];
        end else begin
            c = '0;
            for (int i = 0; i <= 2063; i++) c = edc_upd(c, sec_buf[i]);
            for (int k = 0; k < 4; k++) sec_buf[2064 + k] = c[8*k +: 8];
        end
        if (bad_edc) sec_buf[500] = sec_buf[500] ^ 8'h40;
    endtask

    task automatic send_sector(input bit col, input bit late, input int mode, input bit form2,
                               input bit bad_edc, input bit bad_hdr,
                               input string tag_d, input string tag_s);
        logic [1:0] fmt;
        bit         cbad;
        logic [7:0] esb, key, plain;
        fmt  = bad_hdr ? 2'd0 : (mode == 1) ? 2'd1 : (form2 ? 2'd3 : 2'd2);
        cbad = !bad_hdr && bad_edc && !(mode == 2 && form2);
        esb  = {3'b000, fmt, late, bad_hdr, cbad};
        for (int p = 0; p < SEC; p++) begin
            plain = sec_buf[p];
            if (p < 12) begin
                if (p == 11) begin e_rdy = 0; e_err = 0; g_lfsr = 15'h1; end
                feed(rv(plain), col, 0, 0, 0, 0, 0, "R2");
            end else begin
                for (int j = 0; j < 8; j++) begin
                    key[j] = g_lfsr[0];
                    g_lfsr = {g_lfsr[0] ^ g_lfsr[1], g_lfsr[14:1]};
                end
                if (p <= 15) e_hdr = {e_hdr[23:0], plain};
                if (p == 15) begin e_rdy = 1; e_err = bad_hdr; end
                feed(rv(plain ^ key), col, col, plain, 12'(p), p == SEC - 1, esb,
                     (p == SEC - 1) ? tag_s : tag_d);
            end
        end
    endtask

    task automatic fail_line(input string what, input string tag, input string act, input string exp);
        failures++;
        $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        rst = 1'b1; in_vld = 1'b0; in_byte = '0; collect_en = 1'b0;

        noise(8'h5A); noise(8'h00); noise(8'hFF); noise(8'hFF); noise(8'hFF);
        noise(8'h00); noise(8'h3C); noise(8'h00);
        for (int i = 0; i < 11; i++) noise(8'hFF);   // eleven FF: no sync (R2)
        noise(8'h00); noise(8'h77);

        build_sector(1, 0, 0, 0, 1); send_sector(1, 0, 1, 0, 0, 0, "R1", "R6 R8 R10");
        build_sector(1, 0, 1, 0, 2); send_sector(1, 0, 1, 0, 1, 0, "R1", "R6 R8 R10");
        build_sector(2, 0, 0, 0, 3); send_sector(0, 0, 2, 0, 0, 0, "R4", "R4 R7 R8");
        for (int i = 0; i < 5; i++) noise(8'h5A);
        build_sector(2, 0, 1, 0, 4); send_sector(1, 1, 2, 0, 1, 0, "R3", "R7 R9 R10");
        build_sector(2, 1, 1, 0, 5); send_sector(1, 0, 2, 1, 1, 0, "R1", "R7 R9 R10");
        build_sector(1, 0, 0, 1, 6); send_sector(0, 0, 1, 0, 0, 1, "R5", "R5 R8");

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || stat_wr !== 1'b0 || hdr_rdy !== 1'b0 || hdr_err !== 1'b0 ||
            {hdr_min, hdr_sec, hdr_frm, hdr_mode} !== 32'h0)
            fail_line("reset state", "R11", $sformatf("%b%b%b%b", out_vld, stat_wr, hdr_rdy, hdr_err), "0000");
        rst = 1'b0;

        for (int k = 0; k < q_v.size(); k++) begin
            in_vld = q_v[k]; in_byte = q_in[k]; collect_en = q_col[k];
            @(negedge clk);
            checks++;
            if (out_vld !== q_eov[k] || (q_eov[k] && (out_byte !== q_eob[k] || out_pos !== q_eop[k])))
                fail_line($sformatf("data slot %0d", k), q_tag[k],
                          $sformatf("%b/%h/%0d", out_vld, out_byte, out_pos),
                          $sformatf("%b/%h/%0d", q_eov[k], q_eob[k], q_eop[k]));
            checks++;
            if (stat_wr !== q_esw[k] || (q_esw[k] && stat_byte !== q_esb[k]))
                fail_line($sformatf("status slot %0d", k), q_tag[k],
                          $sformatf("%b/%h", stat_wr, stat_byte), $sformatf("%b/%h", q_esw[k], q_esb[k]));
            checks++;
            if (hdr_rdy !== q_erdy[k] || hdr_err !== q_eerr[k] ||
                {hdr_min, hdr_sec, hdr_frm, hdr_mode} !== q_ehdr[k])
                fail_line($sformatf("header slot %0d R3", k), q_tag[k],
                          $sformatf("%b%b/%h", hdr_rdy, hdr_err, {hdr_min, hdr_sec, hdr_frm, hdr_mode}),
                          $sformatf("%b%b/%h", q_erdy[k], q_eerr[k], q_ehdr[k]));
            if (stat_wr === 1'b1) n_stat++;
            if (stat_wr === 1'b1 && out_vld === 1'b1) n_both++;
        end
        in_vld = 1'b0;
        @(negedge clk);

        checks++;
        if (n_stat != 6) fail_line("status count", "R8", $sformatf("%0d", n_stat), "6");
        checks++;
        if (n_both != 4) fail_line("last byte with status", "R10", $sformatf("%0d", n_both), "4");
        checks++;
        if (out_vld !== 1'b0 || stat_wr !== 1'b0)
            fail_line("quiet after stream", "R12", $sformatf("%b%b", out_vld, stat_wr), "00");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule